// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Master and Slave Modes

This block moves one byte at a time over a four-wire serial link and can act either as the clock-driving master or as a selected slave. A control bit picks the role. Two further bits set the idle level of the serial clock and the edge on which data is centred. A one-byte transmit holding register and a one-byte receive holding register sit next to the shared shift register. A small register port gives software write access to the configuration and divider, and read access to the status flags.

In master mode, a byte written to the data register starts a transfer as soon as the engine is idle. The serial clock is produced from a programmable half-period counter. In slave mode, the block follows an external serial clock while its select input is low. The select input is filtered before it is used. The unfiltered pin level can still be read in the status register.

Top module: `spi_xcvr`

## Requirements
- R1: Register address 0 reads, from bit 7 down to bit 0: busy, master-enable, clock-phase, clock-polarity, slave-selected, raw select pin, shift-register-empty, receive-buffer-empty. Bits 6..4 are writable. After reset, with the select pin high, it reads 0x07.
- R2: Busy reads 1 in master mode from a data write until the last SCK half-period of the byte ends. In slave mode it reads 1 while selected, from the first SCK edge until the byte ends.
- R3: In master mode, a write to address 1 starts a transfer that sends the byte MSB first on MOSI using exactly 16 SCK edges.
- R4: SCK rests at the clock-polarity level whenever no master transfer runs. With clock-phase 0 the first edge falls mid-bit. With clock-phase 1 the first edge falls at the start of the bit.
- R5: Every SCK half-period lasts max(D,1) system clocks, where D is the divider register at address 2.
- R6: The master samples MISO during the last system clock of each bit. The assembled byte goes to the receive buffer and is read back at address 1.
- R7: A slave samples MOSI on the leading edge (clock-phase 0) or the trailing edge (clock-phase 1). It drives MISO MSB first, changing on the other edge. The pending transmit byte is loaded before the first edge.
- R8: The slave-selected bit changes only after the select input has held its new level for 2 consecutive system clocks. The raw bit shows the pin level at the moment of the read.
- R9: Raising the filtered select during a slave byte aborts it. The bit position resets, and the partial byte never reaches the receive buffer.
- R10: In slave mode, shift-register-empty reads 1 after a byte ends with no transmit byte waiting. It reads 0 once a transmit byte loads or any SCK edge arrives. It reads 1 in master mode.
- R11: Receive-buffer-empty reads 0 while an unread byte is held and 1 after address 1 is read. It reads 1 in master mode.
- R12: If a byte completes while the receive buffer is still unread, the byte is dropped and the held byte is kept. The drop sets a sticky overrun flag at address 3 bit 0, which any write to address 3 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 1 empties the receive buffer) |
| reg_addr | input | 2 | Register address: 0 config/status, 1 data, 2 divider, 3 overrun flag |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The hardest states to reach are in slave mode. One is an abort that lands mid-byte after several SCK edges have moved the bit position away from zero. Another is the short select glitch that the filter must swallow. The bench plays the external master itself and drives SCK, MOSI and select at chosen system-clock positions, so it can stop a byte after four bits and hold select high just long enough for the filter to pass it. For the glitch, it lowers select for exactly one clock. It then reads the status before and after the filter window, which separates the raw bit from the filtered one.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_DATA = 2'd1,
    A_DIV  = 2'd2,
    A_FLAG = 2'd3
  } reg_addr_e;

  // SCK level for a given half-period parity
  function automatic logic sck_level(input logic cpol, input logic cpha,
                                     input logic half_odd);
    return cpol ^ (cpha ? ~half_odd : half_odd);
  endfunction

  function automatic logic [7:0] pack_status(
      input logic busy, input logic mst, input logic cpha, input logic cpol,
      input logic sel, input logic raw, input logic srmt, input logic rxbmt);
    return {busy, mst, cpha, cpol, sel, raw, srmt, rxbmt};
  endfunction

endpackage

// File: rtl/spi_ss_filter.sv
module spi_ss_filter #(
  parameter int STABLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n_i,
  output logic ss_filt
);
  localparam int CW = $clog2(STABLE + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      ss_filt <= 1'b1;
    end else if (ss_n_i == ss_filt) begin
      run_q <= '0;
    end else if (run_q == CW'(STABLE - 1)) begin
      run_q   <= '0;
      ss_filt <= ss_n_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_xcvr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  output logic             active,
  output logic             sck,
  output logic             bit_end,
  output logic             done
);
  function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic [DIV_W-1:0] hc_q;
  logic [3:0]       half_q;
  logic             half_end;

  assign half_end = active && (hc_q == half_len(div) - DIV_W'(1));
  assign bit_end  = half_end && half_q[0];
  assign done     = half_end && (half_q == 4'd15);
  assign sck      = active ? sck_level(cpol, cpha, half_q[0]) : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hc_q   <= '0;
      half_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      hc_q   <= '0;
      half_q <= '0;
    end else if (active) begin
      if (half_end) begin
        hc_q   <= '0;
        half_q <= half_q + 4'd1;
        if (half_q == 4'd15) active <= 1'b0;
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sck_i,
  input  logic       cpha,
  output logic       edge_o,
  output logic       sample,
  output logic       shift,
  output logic       done,
  output logic [3:0] ecnt
);
  logic sck_d;

  assign edge_o = en && (sck_i != sck_d);
  assign sample = edge_o && (ecnt[0] == cpha);
  assign shift  = edge_o && (ecnt[0] != cpha) && (ecnt != 4'd0) && (ecnt != 4'd15);
  assign done   = edge_o && (ecnt == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      ecnt  <= '0;
    end else begin
      sck_d <= sck_i;
      if (!en)         ecnt <= '0;
      else if (edge_o) ecnt <= ecnt + 4'd1;
    end
  end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int SS_STABLE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic       ss_n_i
);
  logic             cfg_mst, cfg_cpha, cfg_cpol;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       tx_data, rx_data, sh_q;
  logic             tx_full, rx_full, ovr_q, samp_q, sh_loaded, srmt_q;

  // named internal events
  logic wr_cfg, wr_data, wr_div, wr_flag, rd_data;
  logic ss_filt, sel;
  logic m_start, m_active, m_bit_end, m_done;
  logic s_en, s_edge, s_sample, s_shift, s_done, s_load;
  logic [3:0] s_ecnt;
  logic done_any, busy;
  logic [7:0] new_byte;

  assign wr_cfg  = reg_wr && (reg_addr_e'(reg_addr) == A_CFG);
  assign wr_data = reg_wr && (reg_addr_e'(reg_addr) == A_DATA);
  assign wr_div  = reg_wr && (reg_addr_e'(reg_addr) == A_DIV);
  assign wr_flag = reg_wr && (reg_addr_e'(reg_addr) == A_FLAG);
  assign rd_data = reg_rd && (reg_addr_e'(reg_addr) == A_DATA);

  spi_ss_filter #(.STABLE(SS_STABLE)) i_filt (
    .clk(clk), .rst_n(rst_n), .ss_n_i(ss_n_i), .ss_filt(ss_filt)
  );
  assign sel = !ss_filt;

  assign m_start = cfg_mst && tx_full && !m_active;

  spi_sck_gen #(.DIV_W(DIV_W)) i_sck (
    .clk(clk), .rst_n(rst_n), .start(m_start), .div(div_q),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .active(m_active), .sck(sck_o),
    .bit_end(m_bit_end), .done(m_done)
  );

  assign s_en = !cfg_mst && sel;

  spi_slv_edge i_edge (
    .clk(clk), .rst_n(rst_n), .en(s_en), .sck_i(sck_i), .cpha(cfg_cpha),
    .edge_o(s_edge), .sample(s_sample), .shift(s_shift), .done(s_done),
    .ecnt(s_ecnt)
  );

  assign s_load   = !cfg_mst && tx_full && !sh_loaded && (s_ecnt == 4'd0) && !s_edge;
  assign done_any = m_done || s_done;
  assign new_byte = m_done ? {sh_q[6:0], miso_i}
                           : {sh_q[6:0], (cfg_cpha ? mosi_i : samp_q)};

  assign busy   = cfg_mst ? (m_active || tx_full) : (sel && (s_ecnt != 4'd0));
  assign mosi_o = cfg_mst ? sh_q[7] : 1'b0;
  assign miso_o = cfg_mst ? 1'b0 : sh_q[7];

  // configuration and divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mst  <= 1'b0;
      cfg_cpha <= 1'b0;
      cfg_cpol <= 1'b0;
      div_q    <= '0;
    end else begin
      if (wr_cfg) {cfg_mst, cfg_cpha, cfg_cpol} <= reg_wdata[6:4];
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  // transmit buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data <= '0;
      tx_full <= 1'b0;
    end else if (wr_data) begin
      tx_data <= reg_wdata;
      tx_full <= 1'b1;
    end else if (m_start || s_load || (s_done && tx_full)) begin
      tx_full <= 1'b0;
    end
  end

  // shift register and slave bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      samp_q    <= 1'b0;
      sh_loaded <= 1'b0;
      srmt_q    <= 1'b1;
    end else if (cfg_mst) begin
      sh_loaded <= 1'b0;
      if (m_start)        sh_q <= tx_data;
      else if (m_bit_end) sh_q <= {sh_q[6:0], miso_i};
    end else begin
      if (s_sample) samp_q <= mosi_i;
      if (s_done) begin
        sh_q      <= tx_full ? tx_data : new_byte;
        sh_loaded <= tx_full;
        srmt_q    <= !tx_full;
      end else if (s_shift) begin
        sh_q   <= {sh_q[6:0], samp_q};
        srmt_q <= 1'b0;
      end else if (s_load) begin
        sh_q      <= tx_data;
        sh_loaded <= 1'b1;
        srmt_q    <= 1'b0;
      end else if (s_edge) begin
        srmt_q <= 1'b0;
        if (s_ecnt == 4'd0) sh_loaded <= 1'b0;
      end
    end
  end

  // receive buffer and overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (done_any && rx_full && !rd_data) begin
        ovr_q <= 1'b1;
      end else if (done_any) begin
        rx_data <= new_byte;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
      if (wr_flag && !(done_any && rx_full && !rd_data)) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr))
      A_CFG:   reg_rdata = pack_status(busy, cfg_mst, cfg_cpha, cfg_cpol, sel, ss_n_i,
                                       cfg_mst || srmt_q, cfg_mst || !rx_full);
      A_DATA:  reg_rdata = rx_data;
      A_DIV:   reg_rdata = 8'(div_q);
      default: reg_rdata = {7'd0, ovr_q};
    endcase
  end
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       m_active,
  input logic       sck_o,
  input logic       cfg_cpol,
  input logic       busy,
  input logic       rx_full,
  input logic [7:0] rx_data,
  input logic       ovr_q,
  input logic       rd_data,
  input logic       ss_n_i,
  input logic       ss_filt,
  input logic       s_done
);
  // R4
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_active |-> sck_o == cfg_cpol);

  // R2
  mst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_active |-> busy);

  // R12
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_full) && $stable(rx_data));

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rd_data |=> $stable(rx_data));

  // R8
  sel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_filt) |-> !$past(ss_n_i) && !$past(ss_n_i, 2));

  // R8
  sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_filt) |-> $past(ss_n_i) && $past(ss_n_i, 2));

  // R9
  slv_done_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |-> !ss_filt);
endmodule

bind spi_xcvr spi_xcvr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .m_active(m_active), .sck_o(sck_o),
  .cfg_cpol(cfg_cpol), .busy(busy), .rx_full(rx_full), .rx_data(rx_data),
  .ovr_q(ovr_q), .rd_data(rd_data), .ss_n_i(ss_n_i), .ss_filt(ss_filt),
  .s_done(s_done)
);

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic sck_o, mosi_o, miso_o;
  logic miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] bm_tx, bm_rx;
  int bm_ecnt;

  always #10 clk = ~clk;

  spi_xcvr i_spi_xcvr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
    .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i)
  );

  function automatic int exp_half(input logic [7:0] d);
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  function automatic logic [7:0] exp_stat(input bit busy, mst, cpha, cpol, sel,
                                          raw, srmt, rxbmt);
    logic [7:0] s;
    s[0] = rxbmt; s[1] = srmt; s[2] = raw; s[3] = sel;
    s[4] = cpol;  s[5] = cpha; s[6] = mst; s[7] = busy;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic m_xfer(input bit cpol, input bit cpha, input logic [7:0] div,
                        input logic [7:0] tx, input logic [7:0] mi, input bit do_read);
    int h, edges, since, badhalf, busybad;
    logic prev;
    logic [7:0] d;
    h = exp_half(div);
    reg_write(2'd0, {1'b0, 1'b1, cpha, cpol, 4'h0});
    reg_write(2'd2, div);
    bm_tx = mi; bm_rx = 8'd0; bm_ecnt = 0; miso_i = mi[7];
    check(sck_o === cpol, "R4", "idle sck before start", sck_o, cpol);
    reg_write(2'd1, tx);
    reg_addr = 2'd0; reg_rd = 1'b1;
    edges = 0; since = 0; badhalf = 0; busybad = 0; prev = sck_o;
    for (int c = 0; c < 16 * h + 3; c++) begin
      @(negedge clk);
      since++;
      if (sck_o !== prev) begin
        edges++;
        if (edges > 1 && since != h) badhalf++;
        since = 0;
        prev = sck_o;
        if ((bm_ecnt % 2) == int'(cpha)) bm_rx = {bm_rx[6:0], mosi_o};
        else if (!(cpha && bm_ecnt == 0)) begin
          bm_tx = {bm_tx[6:0], 1'b0};
          miso_i = bm_tx[7];
        end
        bm_ecnt++;
      end
      if (edges < 16 && reg_rdata[7] !== 1'b1) busybad++;
    end
    reg_rd = 1'b0;
    check(edges == 16, "R3", "sck edge count", edges, 16);
    check(badhalf == 0, "R5", "half-period violations", badhalf, 0);
    check(busybad == 0, "R2", "master busy gaps", busybad, 0);
    check(bm_rx == tx, "R3", "mosi byte", bm_rx, tx);
    check(sck_o === cpol, "R4", "idle sck after end", sck_o, cpol);
    reg_read(2'd0, d);
    check(d == exp_stat(0, 1, cpha, cpol, 0, 1, 1, 1), "R10", "master status",
          d, exp_stat(0, 1, cpha, cpol, 0, 1, 1, 1));
    if (do_read) begin
      reg_read(2'd1, d);
      check(d == mi, "R6", "master rx byte", d, mi);
    end
  endtask

  task automatic s_xfer(input bit cpol, input bit cpha, input logic [7:0] mo,
                        input int nbits, output logic [7:0] mi);
    mi = 8'd0;
    if (ss_n_i) begin
      ss_n_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi_i = mo[7 - i];
        repeat (4) @(negedge clk);
        mi = {mi[6:0], miso_o};
        sck_i = ~cpol;
        repeat (4) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = mo[7 - i];
        repeat (4) @(negedge clk);
        mi = {mi[6:0], miso_o};
        sck_i = cpol;
        repeat (4) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic main;
    logic [7:0] d, mi, a, b;
    bit cpol, cpha;
    void'($urandom(32'h5A17C3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, d);
    check(d == 8'h07, "R1", "reset status", d, 8'h07);
    reg_write(2'd2, 8'd3);
    reg_read(2'd2, d);
    check(d == 8'd3, "R5", "divider readback", d, 8'd3);

    // master: directed corners then random
    m_xfer(0, 0, 8'd0, 8'hA5, 8'h3C, 1);
    m_xfer(1, 1, 8'd1, 8'h01, 8'h80, 1);
    for (int k = 0; k < 6; k++)
      m_xfer($urandom() % 2, $urandom() % 2, 8'($urandom() % 5),
             8'($urandom()), 8'($urandom()), 1);

    // R12 overrun
    m_xfer(0, 1, 8'd1, 8'h11, 8'hC3, 0);
    m_xfer(0, 1, 8'd1, 8'h22, 8'h5E, 0);
    reg_read(2'd3, d);
    check(d[0] == 1'b1, "R12", "overrun flag set", d, 1);
    reg_read(2'd1, d);
    check(d == 8'hC3, "R12", "older byte kept", d, 8'hC3);
    reg_write(2'd3, 8'h00);
    reg_read(2'd3, d);
    check(d[0] == 1'b0, "R12", "overrun cleared", d, 0);

    // slave random transfers
    for (int k = 0; k < 6; k++) begin
      cpol = $urandom() % 2; cpha = $urandom() % 2;
      a = 8'($urandom()); b = 8'($urandom());
      reg_write(2'd0, {1'b0, 1'b0, cpha, cpol, 4'h0});
      sck_i = cpol;
      reg_write(2'd1, a);
      reg_read(2'd0, d);
      check(d[1] == 1'b0, "R10", "srmt after tx load", d[1], 0);
      s_xfer(cpol, cpha, b, 8, mi);
      check(mi == a, "R7", "miso byte", mi, a);
      reg_read(2'd0, d);
      check(d == exp_stat(0, 0, cpha, cpol, 1, 0, 1, 0), "R10", "slave status after byte",
            d, exp_stat(0, 0, cpha, cpol, 1, 0, 1, 0));
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
      reg_read(2'd1, d);
      check(d == b, "R7", "slave rx byte", d, b);
      reg_read(2'd0, d);
      check(d[0] == 1'b1, "R11", "rxbmt after read", d[0], 1);
    end

    // R8 glitch and raw pin
    reg_write(2'd0, 8'h00);
    sck_i = 1'b0;
    @(negedge clk); ss_n_i = 1'b0;
    @(negedge clk); ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
    reg_read(2'd0, d);
    check(d[3] == 1'b0, "R8", "one-clock glitch ignored", d[3], 0);
    @(negedge clk); ss_n_i = 1'b0;
    reg_addr = 2'd0; reg_rd = 1'b1;
    #2 d = reg_rdata;
    check(d[2] == 1'b0 && d[3] == 1'b0, "R8", "raw low, filtered not yet", d[3:2], 0);
    @(negedge clk); #2 d = reg_rdata;
    check(d[3] == 1'b0, "R8", "selected after one clock", d[3], 0);
    @(negedge clk); #2 d = reg_rdata;
    check(d[3] == 1'b1, "R8", "selected after two clocks", d[3], 1);
    reg_rd = 1'b0;

    // R9 abort mid-byte
    s_xfer(0, 0, 8'hF0, 4, mi);
    reg_read(2'd0, d);
    check(d[7] == 1'b1, "R2", "slave busy mid-byte", d[7], 1);
    check(d[1] == 1'b0, "R10", "srmt cleared by sck edges", d[1], 0);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(2'd0, d);
    check(d[7] == 1'b0 && d[0] == 1'b1, "R9", "abort leaves idle and empty",
          {d[7], d[0]}, 2'b01);
    s_xfer(0, 0, 8'h6B, 8, mi);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    reg_read(2'd1, d);
    check(d == 8'h6B, "R9", "byte after abort", d, 8'h6B);
    reg_read(2'd0, d);
    check(d[0] == 1'b1, "R11", "rxbmt after read", d[0], 1);
  endtask

  initial begin
    fork
      main();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule